// File: doc/BRIEF.md
# Predicated Merging Vector Floating-Point Subtractor

This block takes two vector operands, a byte-granular predicate and a two-bit element size code. It returns a vector in which every active lane holds the IEEE-754 difference of the first operand minus the second. The difference is rounded to nearest with ties to even, and subnormals are handled in full. Every inactive lane carries the first operand through untouched. The result is meant to overwrite the first operand's register image, so the block acts as the execution stage of a destructive, merge-predicated subtract.

The vector length is a parameter and must be a multiple of 128 bits. The element width can be 16, 32 or 64 bits, and the number of lanes is the vector length divided by that width. The predicate holds one bit per byte of the vector, and a lane takes its enable from the bit at the lane's lowest byte. An operation is accepted on a valid/ready handshake. Its result appears one cycle later and is held until the consumer takes it. The block drives no flags and no status, apart from an error bit for the one undefined size code.

Top module: `vfsub_predicated`

## Requirements
- R1: The size code selects the lane format: 2'b01 is binary16 (5-bit exponent), 2'b10 is binary32 (8-bit exponent) and 2'b11 is binary64 (11-bit exponent). Lane i occupies bits [i*W +: W] of each vector, and there are VLEN/W lanes.
- R2: An active lane returns first operand minus second operand, rounded to nearest-even, with subnormal inputs and results computed exactly rather than flushed. This includes a rounding carry that moves the result into the next binade.
- R3: Lane i is active exactly when predicate bit i*W/8 is 1. Every other predicate bit within the lane has no effect on the output.
- R4: An inactive lane outputs its first-operand bits unchanged, and an all-zero predicate returns the first operand exactly.
- R5: If either input is a NaN, or the operation is infinity minus an infinity of the same sign, the lane returns the default quiet NaN: sign 0, exponent all ones, and only the top fraction bit set (16'h7E00, 32'h7FC00000, 64'h7FF8000000000000).
- R6: An exact zero difference of finite operands is +0, except that -0 minus +0 is -0.
- R7: A finite difference whose rounded magnitude exceeds the largest finite value returns infinity carrying the sign of the difference.
- R8: Size code 2'b00 sets out_err with that result, and the output vector equals the first operand. Every other size code leaves out_err at 0.
- R9: An operation is accepted on a cycle where in_valid and in_ready are both high, and out_valid rises on the next clock edge. While out_valid is high and out_ready is low, out_data and out_err hold and in_ready is low. out_valid falls after a cycle with out_ready high, unless a new operation was accepted in that same cycle.
- R10: After a synchronous active-low reset, out_valid and out_err are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can accept an operation |
| in_a | input | VLEN | First operand, minuend and merge source |
| in_b | input | VLEN | Second operand, subtrahend |
| in_pred | input | VLEN/8 | Predicate, one bit per byte |
| in_size | input | 2 | Element size code |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VLEN | Merged result vector |
| out_err | output | 1 | Size code was undefined |

## Verification
The bench targets the following corner cases:
- Signed zero results, where a sign mistake turns -0 minus +0 into +0 or x minus x into -0.
- Same-sign infinity pairs and NaN inputs, which a careless design passes through as an input payload instead of the default NaN.
- The rounding carry from an all-ones significand into the next exponent, and the crossing between the smallest normal and the largest subnormal. Errors here show up as a one-ulp error or a flushed zero.
- Predicates with only the non-leading bytes of a lane set. These expose decoding by the wrong byte.
- Size code 00, where a lane computed anyway would corrupt the returned vector.

// File: rtl/vfsub_pkg.sv
// Package: shared size codes and per-format geometry for the vector
// subtractor. Assumes format index k = 0,1,2 stands for 16/32/64-bit lanes.
package vfsub_pkg;

    typedef enum logic [1:0] {
        SZ_NONE   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_DOUBLE = 2'b11
    } vfsub_size_e;

    localparam int GRAN_BITS = 16;   // smallest lane width
    localparam int NUM_FMT   = 3;

    // Lane width in bits for format index k.
    function automatic int fmt_width(input int k);
        return GRAN_BITS << k;
    endfunction

    // Exponent field width for format index k.
    function automatic int fmt_exp(input int k);
        return (k == 0) ? 5 : ((k == 1) ? 8 : 11);
    endfunction

endpackage

// File: rtl/vfsub_lane_mask.sv
// Module: turns the byte predicate into one enable per 16-bit granule of
// the vector. Every granule takes the bit of the lowest byte of the lane it
// belongs to under the selected size. Assumes VLEN is a multiple of 128.
// Size code 00 yields an all-zero mask.
module vfsub_lane_mask #(
    parameter int VLEN = 128
) (
    input  logic [VLEN/8-1:0]                     pred,
    input  logic [1:0]                            size,
    output logic [VLEN/vfsub_pkg::GRAN_BITS-1:0]  gmask
);
    import vfsub_pkg::*;

    localparam int NG = VLEN / GRAN_BITS;

    // Per granule, find the lane base byte for the size and read its bit.
    always_comb begin
        gmask = '0;
        for (int j = 0; j < NG; j++) begin
            case (size)
                SZ_HALF:   gmask[j] = pred[2 * j];
                SZ_SINGLE: gmask[j] = pred[2 * ((j >> 1) << 1)];
                SZ_DOUBLE: gmask[j] = pred[2 * ((j >> 2) << 2)];
                default:   gmask[j] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/vfsub_fp_lane.sv
// Module: combinational IEEE-754 subtract of one lane, op_a - op_b.
// Rounds to nearest-even and keeps subnormals. Returns the default quiet NaN
// for NaN inputs and for same-sign infinity differences. Assumes EW >= 3
// and MW >= 2.
module vfsub_fp_lane #(
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  logic [EW+MW:0] op_a,
    input  logic [EW+MW:0] op_b,
    output logic [EW+MW:0] diff
);
    localparam int W  = 1 + EW + MW;
    localparam int XW = MW + 4;            // hidden + fraction + guard/round/sticky
    localparam int SW = XW + 1;            // plus carry
    localparam logic [EW-1:0] EMAX = {EW{1'b1}};

    logic          sa, sb, sl, ss, swap;
    logic [EW-1:0] exa, exb, el, es, dexp;
    logic [MW-1:0] fa, fb;
    logic [MW:0]   ml, ms;
    logic          a_nan, b_nan, a_inf, b_inf;
    logic [XW-1:0] bigx, smx, smj;
    logic          stk;
    logic [SW-1:0] sum, norm;
    logic [EW:0]   e0, e1, efield;
    logic [EW+MW:0] packed_v, rounded;
    logic          rup;
    int            dint, lz, lim, sh;

    // Classify, align, add or subtract magnitudes, normalize, round, pack.
    always_comb begin
        sa    = op_a[W-1];
        sb    = ~op_b[W-1];                 // subtract = add negated operand
        exa   = op_a[W-2:MW];
        exb   = op_b[W-2:MW];
        fa    = op_a[MW-1:0];
        fb    = op_b[MW-1:0];
        a_nan = (exa == EMAX) && (fa != '0);
        b_nan = (exb == EMAX) && (fb != '0);
        a_inf = (exa == EMAX) && (fa == '0);
        b_inf = (exb == EMAX) && (fb == '0);

        swap = {exb, fb} > {exa, fa};
        sl   = swap ? sb : sa;
        ss   = swap ? sa : sb;
        el   = swap ? ((exb == '0) ? EW'(1) : exb) : ((exa == '0) ? EW'(1) : exa);
        es   = swap ? ((exa == '0) ? EW'(1) : exa) : ((exb == '0) ? EW'(1) : exb);
        ml   = swap ? {exb != '0, fb} : {exa != '0, fa};
        ms   = swap ? {exa != '0, fa} : {exb != '0, fb};
        dexp = el - es;
        dint = int'(dexp);

        bigx = {ml, 3'b000};
        smx  = {ms, 3'b000};
        stk  = 1'b0;
        for (int i = 0; i < XW; i++) begin
            if (i < dint) stk = stk | smx[i];
        end
        smj = ((dint >= XW) ? '0 : (smx >> dint)) | {{(XW-1){1'b0}}, stk};

        if (sl == ss) sum = {1'b0, bigx} + {1'b0, smj};
        else          sum = {1'b0, bigx} - {1'b0, smj};

        e0 = {1'b0, el};
        lz = XW;
        for (int i = 0; i < XW; i++) begin
            if (sum[i]) lz = XW - 1 - i;
        end
        lim = int'(e0) - 1;
        sh  = (lz < lim) ? lz : lim;

        if (sum[SW-1]) begin
            norm = {1'b0, sum[SW-1:2], sum[1] | sum[0]};
            e1   = e0 + 1'b1;
        end else begin
            norm = sum << sh;
            e1   = e0 - (EW+1)'(sh);
        end

        efield   = norm[SW-2] ? e1 : '0;
        rup      = norm[2] & (norm[1] | norm[0] | norm[3]);
        packed_v = {efield, norm[SW-3:3]};
        rounded  = packed_v + {{(EW+MW){1'b0}}, rup};

        if (a_nan || b_nan || (a_inf && b_inf && (sa != sb)))
            diff = {1'b0, EMAX, 1'b1, {(MW-1){1'b0}}};
        else if (a_inf)
            diff = op_a;
        else if (b_inf)
            diff = {sb, EMAX, {MW{1'b0}}};
        else if (sum == '0)
            diff = {sl & ss, {(EW+MW){1'b0}}};
        else if (rounded[EW+MW:MW] >= {1'b0, EMAX})
            diff = {sl, EMAX, {MW{1'b0}}};
        else
            diff = {sl, rounded[EW+MW-1:0]};
    end

endmodule

// File: rtl/vfsub_predicated.sv
// Module: top of the predicated merging vector subtractor. It holds one
// lane bank per format, picks the bank for the size code, merges it per
// 16-bit granule against the first operand and registers the result
// behind a valid/ready handshake. Assumes VLEN is a multiple of 128.
module vfsub_predicated #(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VLEN-1:0]   in_a,
    input  logic [VLEN-1:0]   in_b,
    input  logic [VLEN/8-1:0] in_pred,
    input  logic [1:0]        in_size,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VLEN-1:0]   out_data,
    output logic              out_err
);
    import vfsub_pkg::*;

    localparam int NG = VLEN / GRAN_BITS;

    logic [NUM_FMT-1:0][VLEN-1:0] bank;
    logic [VLEN-1:0]              picked, merged;
    logic [NG-1:0]                gmask;
    logic                         accept;

    vfsub_lane_mask #(.VLEN(VLEN)) u_mask (
        .pred  (in_pred),
        .size  (in_size),
        .gmask (gmask)
    );

    for (genvar k = 0; k < NUM_FMT; k++) begin : g_fmt
        localparam int LW = fmt_width(k);
        localparam int EW = fmt_exp(k);
        localparam int MW = LW - 1 - EW;
        for (genvar i = 0; i < VLEN / LW; i++) begin : g_lane
            vfsub_fp_lane #(.EW(EW), .MW(MW)) u_lane (
                .op_a (in_a[i*LW +: LW]),
                .op_b (in_b[i*LW +: LW]),
                .diff (bank[k][i*LW +: LW])
            );
        end
    end

    // Select the lane bank that matches the size code.
    always_comb begin
        case (in_size)
            SZ_HALF:   picked = bank[0];
            SZ_SINGLE: picked = bank[1];
            SZ_DOUBLE: picked = bank[2];
            default:   picked = in_a;
        endcase
    end

    for (genvar j = 0; j < NG; j++) begin : g_merge
        // Keep the first operand wherever the granule's lane is inactive.
        assign merged[j*GRAN_BITS +: GRAN_BITS] =
            gmask[j] ? picked[j*GRAN_BITS +: GRAN_BITS] : in_a[j*GRAN_BITS +: GRAN_BITS];
    end

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    // Output register with handshake: load on accept, drop on consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= merged;
            out_err   <= (in_size == SZ_NONE);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/vfsub_predicated_chk.sv
// Checker: handshake and merge properties of vfsub_predicated. It captures
// the first operand, predicate and size of each accepted operation so that
// the result can be related to them.
module vfsub_predicated_chk #(
    parameter int VLEN = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [VLEN-1:0]   in_a,
    input logic [VLEN/8-1:0] in_pred,
    input logic [1:0]        in_size,
    input logic              out_valid,
    input logic              out_ready,
    input logic [VLEN-1:0]   out_data,
    input logic              out_err
);
    logic [VLEN-1:0]   cap_a;
    logic [VLEN/8-1:0] cap_pred;
    logic [1:0]        cap_size;

    // Capture the operands of each accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a    <= '0;
            cap_pred <= '0;
            cap_size <= 2'b01;
        end else if (in_valid && in_ready) begin
            cap_a    <= in_a;
            cap_pred <= in_pred;
            cap_size <= in_size;
        end
    end

    a_r9_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !(in_valid && in_ready)) |=> !out_valid);

    a_r8_err_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cap_size == 2'b00) |-> (out_err && out_data == cap_a));

    a_r8_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cap_size != 2'b00) |-> !out_err);

    a_r4_all_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cap_pred == '0) |-> (out_data == cap_a));

endmodule

bind vfsub_predicated vfsub_predicated_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_pred   (in_pred),
    .in_size   (in_size),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_err   (out_err)
);

// File: tb/vfsub_predicated_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios, each task checks its own results against a
// reference model built on real arithmetic.
module vfsub_predicated_test;
    localparam int VLEN = 128;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [VLEN-1:0] in_a = '0, in_b = '0;
    logic [PW-1:0]   in_pred = '0;
    logic [1:0]      in_size = 2'b01;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [VLEN-1:0] out_data;
    logic            out_err;

    int nvec = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    vfsub_predicated #(.VLEN(VLEN)) uut (.*);

    // ---------------- reference model ----------------
    function automatic real p2(int n);
        real r = 1.0;
        if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
        else        for (int i = 0; i < -n; i++) r = r * 0.5;
        return r;
    endfunction

    function automatic real to_r(int ew, int mw, logic [63:0] x);
        longint unsigned e = (x >> mw) & ((64'd1 << ew) - 1);
        longint unsigned f = x & ((64'd1 << mw) - 1);
        int bias = (1 << (ew - 1)) - 1;
        real v;
        if (e == 0) v = real'(f) * p2(1 - bias - mw);
        else        v = (real'(f) + p2(mw)) * p2(int'(e) - bias - mw);
        return x[ew + mw] ? -v : v;
    endfunction

    function automatic logic [63:0] from_r(int ew, int mw, real v);
        int bias = (1 << (ew - 1)) - 1;
        longint unsigned emax = (64'd1 << ew) - 1;
        logic [63:0] sgn = $realtobits(v) >> 63;
        real av = (v < 0.0) ? -v : v;
        int e = 0;
        real sc, q, rem;
        longint unsigned qi, pk;
        if (av == 0.0) return sgn << (ew + mw);
        while (av >= p2(e + 1)) e++;
        while (av < p2(e)) e--;
        if (e < 1 - bias) e = 1 - bias;
        sc  = av * p2(mw - e);
        q   = $floor(sc);
        rem = sc - q;
        qi  = longint'(q);
        if (rem > 0.5 || (rem == 0.5 && qi[0])) qi++;
        pk = (longint'(e + bias - 1) << mw) + qi;
        if (pk >= (emax << mw)) pk = emax << mw;
        return (sgn << (ew + mw)) | pk;
    endfunction

    function automatic logic [63:0] ref_lane(int w, logic [63:0] a, logic [63:0] b);
        int ew = (w == 16) ? 5 : ((w == 32) ? 8 : 11);
        int mw = w - 1 - ew;
        longint unsigned emax = (64'd1 << ew) - 1;
        longint unsigned fm = (64'd1 << mw) - 1;
        logic an = (((a >> mw) & emax) == emax) && ((a & fm) != 0);
        logic bn = (((b >> mw) & emax) == emax) && ((b & fm) != 0);
        logic ai = (((a >> mw) & emax) == emax) && ((a & fm) == 0);
        logic bi = (((b >> mw) & emax) == emax) && ((b & fm) == 0);
        logic sa = a[w-1], sb = b[w-1];
        logic [63:0] qnan = (emax << mw) | (64'd1 << (mw - 1));
        if (an || bn || (ai && bi && sa == sb)) return qnan;
        if (ai) return a;
        if (bi) return b ^ (64'd1 << (w - 1));
        if (w == 64) return $realtobits($bitstoreal(a) - $bitstoreal(b));
        return from_r(ew, mw, to_r(ew, mw, a) - to_r(ew, mw, b));
    endfunction

    function automatic logic [VLEN-1:0] exp_vec(logic [VLEN-1:0] a, logic [VLEN-1:0] b,
                                                logic [PW-1:0] p, logic [1:0] sz);
        logic [VLEN-1:0] r = a;
        int w;
        if (sz == 2'b00) return a;
        w = 16 << (sz - 1);
        for (int i = 0; i < VLEN / w; i++) begin
            if (p[i * w / 8]) begin
                logic [63:0] la = 64'(a >> (i * w));
                logic [63:0] lb = 64'(b >> (i * w));
                logic [63:0] m  = (w == 64) ? '1 : ((64'd1 << w) - 1);
                logic [63:0] rl = ref_lane(w, la & m, lb & m) & m;
                for (int k = 0; k < w; k++) r[i * w + k] = rl[k];
            end
        end
        return r;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(string req, logic [VLEN-1:0] got, logic [VLEN-1:0] expv);
        nvec++;
        if (got !== expv) begin
            nfail++;
            $display("FAIL %s got=%h expected=%h", req, got, expv);
        end
    endtask

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Apply one op with out_ready high; return the output seen one cycle later.
    task automatic run_op(logic [VLEN-1:0] a, logic [VLEN-1:0] b, logic [PW-1:0] p,
                          logic [1:0] sz, output logic [VLEN-1:0] res, output logic err);
        @(negedge clk);
        in_a = a; in_b = b; in_pred = p; in_size = sz; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 out_valid one cycle after accept", {{(VLEN-1){1'b0}}, out_valid}, 1);
        res = out_data;
        err = out_err;
    endtask

    task automatic op_chk(string req, logic [VLEN-1:0] a, logic [VLEN-1:0] b,
                          logic [PW-1:0] p, logic [1:0] sz);
        logic [VLEN-1:0] res;
        logic err;
        run_op(a, b, p, sz, res, err);
        check(req, res, exp_vec(a, b, p, sz));
        if (sz != 2'b00) check("R8 out_err low for defined size", {{(VLEN-1){1'b0}}, err}, 0);
    endtask

    function automatic logic [63:0] mkf(int w, bit s, longint e, longint f);
        int ew = (w == 16) ? 5 : ((w == 32) ? 8 : 11);
        int mw = w - 1 - ew;
        return (64'(s) << (w - 1)) | (64'(e) << mw) | 64'(f);
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset out_valid", {{(VLEN-1){1'b0}}, out_valid}, 0);
        check("R10 reset out_err", {{(VLEN-1){1'b0}}, out_err}, 0);
        check("R10 reset in_ready", {{(VLEN-1){1'b0}}, in_ready}, 1);
    endtask

    task automatic t_random_full(logic [1:0] sz, int n);
        for (int i = 0; i < n; i++)
            op_chk("R1 R2 random all-active", rnd_vec(), rnd_vec(), '1, sz);
    endtask

    task automatic t_near_cancel(logic [1:0] sz, int n);
        for (int i = 0; i < n; i++) begin
            logic [VLEN-1:0] a = rnd_vec();
            logic [VLEN-1:0] b = a;
            for (int g = 0; g < VLEN / 16; g++) b[g*16 +: 4] = 4'($urandom);
            op_chk("R2 R6 near cancellation", a, b, '1, sz);
        end
    endtask

    task automatic t_predicates(logic [1:0] sz);
        int w = 16 << (sz - 1);
        logic [PW-1:0] pnl = '1;     // every bit set except each lane's lowest byte
        for (int i = 0; i < VLEN / w; i++) pnl[i * w / 8] = 1'b0;
        op_chk("R3 R4 random predicate", rnd_vec(), rnd_vec(), PW'($urandom), sz);
        op_chk("R3 non-leading bytes ignored", rnd_vec(), rnd_vec(), pnl, sz);
        op_chk("R4 all inactive", rnd_vec(), rnd_vec(), '0, sz);
        op_chk("R3 only leading bytes", rnd_vec(), rnd_vec(), ~pnl, sz);
    endtask

    task automatic t_corners(logic [1:0] sz);
        int w = 16 << (sz - 1);
        int ew = (w == 16) ? 5 : ((w == 32) ? 8 : 11);
        int mw = w - 1 - ew;
        longint em = (longint'(1) << ew) - 1;
        longint bias = (longint'(1) << (ew - 1)) - 1;
        longint fall = (longint'(1) << mw) - 1;
        int nl = VLEN / w;
        logic [63:0] pa[14], pb[14];
        logic [VLEN-1:0] a = '0, b = '0;
        pa[0]  = mkf(w,0,0,0);        pb[0]  = mkf(w,0,0,0);          // +0 - +0
        pa[1]  = mkf(w,1,0,0);        pb[1]  = mkf(w,0,0,0);          // -0 - +0
        pa[2]  = mkf(w,0,bias,5);     pb[2]  = mkf(w,0,bias,5);       // x - x
        pa[3]  = mkf(w,0,em,0);       pb[3]  = mkf(w,0,em,0);         // inf - inf
        pa[4]  = mkf(w,1,em,1);       pb[4]  = mkf(w,0,bias,0);       // NaN - 1
        pa[5]  = mkf(w,0,em,0);       pb[5]  = mkf(w,1,em,0);         // inf - -inf
        pa[6]  = mkf(w,0,0,1);        pb[6]  = mkf(w,0,0,0);          // min subnormal
        pa[7]  = mkf(w,0,1,0);        pb[7]  = mkf(w,0,0,1);          // normal -> subnormal
        pa[8]  = mkf(w,0,em-1,fall);  pb[8]  = mkf(w,1,em-1,fall);    // overflow +inf
        pa[9]  = mkf(w,0,bias,fall);  pb[9]  = mkf(w,1,bias-mw-1,0);  // rounding carry
        pa[10] = mkf(w,0,0,1);        pb[10] = mkf(w,1,0,1);          // subnormal sum
        pa[11] = mkf(w,1,em-1,fall);  pb[11] = mkf(w,0,em-1,fall);    // overflow -inf
        pa[12] = mkf(w,0,bias,0);     pb[12] = mkf(w,0,0,1);          // sticky only
        pa[13] = mkf(w,0,3,7);        pb[13] = mkf(w,0,em,3);         // NaN in second
        for (int p = 0; p < 14; p++) begin
            int ln = p % nl;
            for (int k = 0; k < w; k++) begin
                a[ln * w + k] = pa[p][k];
                b[ln * w + k] = pb[p][k];
            end
            if (ln == nl - 1 || p == 13)
                op_chk("R2 R5 R6 R7 corner operands", a, b, '1, sz);
        end
    endtask

    task automatic t_bad_size();
        logic [VLEN-1:0] a = rnd_vec();
        logic [VLEN-1:0] res;
        logic err;
        run_op(a, rnd_vec(), '1, 2'b00, res, err);
        check("R8 size 00 returns first operand", res, a);
        check("R8 size 00 raises out_err", {{(VLEN-1){1'b0}}, err}, 1);
    endtask

    task automatic t_backpressure();
        logic [VLEN-1:0] a = rnd_vec(), b = rnd_vec();
        logic [VLEN-1:0] e = exp_vec(a, b, '1, 2'b10);
        @(negedge clk);
        out_ready = 1'b0;
        in_a = a; in_b = b; in_pred = '1; in_size = 2'b10; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_a = rnd_vec();
        for (int c = 0; c < 3; c++) begin
            check("R9 held while stalled", out_data, e);
            check("R9 valid held while stalled", {{(VLEN-1){1'b0}}, out_valid}, 1);
            check("R9 in_ready low while stalled", {{(VLEN-1){1'b0}}, in_ready}, 0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check("R9 valid drops after consume", {{(VLEN-1){1'b0}}, out_valid}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 190000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        t_reset();
        for (int s = 1; s < 4; s++) begin
            t_random_full(2'(s), 40);
            t_near_cancel(2'(s), 20);
            t_predicates(2'(s));
            t_corners(2'(s));
        end
        t_bad_size();
        t_backpressure();
        op_chk("R1 R2 after backpressure", rnd_vec(), rnd_vec(), '1, 2'b11);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule